// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours, day of week, day of month, month with a century bit, and a two-digit year. A parameterised divider turns the block clock into a once-per-second advance. Each advance ripples through the fields with correct month lengths and leap-year February. Hours are held either in 24-hour form or in a 12-hour form where bit 5 marks the afternoon.

A host bus reaches the fields through a flat register port indexed by field number. A write replaces one field in a single cycle, and a read returns the addressed field one cycle later. A write to the seconds field restarts the sub-second divider, so software can align the next second boundary with its own write. The block drives five single-cycle carry strobes: second, minute, hour, day and month. These feed alarm and periodic-interrupt logic placed next to it.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds (index 0) and minutes (index 1) count in BCD from 0x00 to 0x59. On each advance, 0x59 becomes 0x00 and carries into the next field. Any other value increments by one in BCD.
- R2: Bits that hold no data read as 0, and writes to them are dropped. These bits are: bit 7 of seconds and minutes, bits 7:6 of hours and day of month, bits 7:3 of day of week, and bits 6:5 of month. Index 7 holds no field, always reads 0x00, and ignores writes.
- R3: With `mode24`=0 the hour field (index 2) follows 0x12, 0x01 … 0x11, 0x32, 0x21 … 0x31, then back to 0x12. Bit 5 is the PM flag. Only the step from 0x31 to 0x12 advances the day.
- R4: With `mode24`=1 the hour field runs 0x00 to 0x23. Only the step from 0x23 to 0x00 advances the day.
- R5: Day of week (index 3, bits 2:0) advances with every day advance, counting 0 to 6 and wrapping to 0.
- R6: Day of month (index 4) counts from 0x01 to the month's last day, then returns to 0x01 and advances the month. The last day is 0x30 for months 04, 06, 09 and 11, and 0x31 for the other months except February. February ends on 0x29 when the BCD year's value is a multiple of 4, and on 0x28 otherwise.
- R7: Month (index 5, bits 4:0) runs 0x01 to 0x12. After 0x12 it returns to 0x01 and advances the year (index 6). The year runs 0x00 to 0x99. When the year wraps from 0x99 to 0x00, month bit 7 (the century bit) toggles.
- R8: A write to seconds clears the sub-second divider. The next advance comes exactly TICK_DIV clock cycles after the write edge, and no advance happens in between.
- R9: Each strobe is high for exactly one cycle, on the same edge that the field update becomes visible. `sec_stb` pulses on every advance. `min_stb` pulses when seconds wrap, `hour_stb` when minutes wrap, `day_stb` when the day advances, and `mon_stb` when the month advances. Each strobe implies the one before it in that list.
- R10: `rd_data` shows the field chosen by `rd_addr` one clock after it is sampled. Indices are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year.
- R11: Changing `mode24` does not rewrite the stored hour. Only the way later advances interpret bit 5 changes.
- R12: After reset the fields read as follows: seconds 0x00, minutes 0x00, hours 0x12 (12-hour) or 0x00 (24-hour), day of week 0, day of month 0x01, month 0x01, year 0x00. All strobes read low.
- R13: A host write to a field other than seconds that coincides with an advance delays that advance by one cycle. The advance is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the divider counts its cycles |
| rst | input | 1 | Synchronous active-high reset |
| mode24 | input | 1 | 1 selects 24-hour counting, 0 selects 12-hour with PM flag |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Field index to write |
| wr_data | input | 8 | Write value in packed BCD |
| rd_addr | input | 3 | Field index to read |
| rd_data | output | 8 | Registered read value |
| sec_stb | output | 1 | One-cycle pulse on each second advance |
| min_stb | output | 1 | One-cycle pulse when seconds wrap |
| hour_stb | output | 1 | One-cycle pulse when minutes wrap |
| day_stb | output | 1 | One-cycle pulse when the day advances |
| mon_stb | output | 1 | One-cycle pulse when the month advances |

## Verification
A short divider keeps each advance to a few cycles, so every second and minute value is swept through one advance. All 24 hours are swept in both hour modes, which separates the PM-flag sequence from plain 24-hour counting. Each hour step also checks that only the last hour of the day raises the day strobe. The calendar sweeps cover the last day of every month over eight years, and February 28 over all hundred years. These sweeps tell leap years from common years and 30-day months from 31-day months, and the century bit is checked on the 99-to-00 wrap. Directed cases time the first advance after a seconds write, a restarted divider, a write that lands on the advance edge, the read-as-zero masks, and a mode change over a stored hour.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] A_WDAY = 3'd3;
  localparam logic [ADDR_W-1:0] A_MDAY = 3'd4;
  localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
  localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;

  typedef struct packed {
    logic [5:0] hour;
    logic       day;
  } hour_step_t;

  // one BCD increment of a two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = v + 8'd1;
    return r;
  endfunction

  // BCD year is a leap year when (10*tens + ones) mod 4 == 0,
  // which equals (2*tens + ones) mod 4
  function automatic logic is_leap(input logic [7:0] y);
    logic [7:0] s;
    s = {3'b000, y[7:4], 1'b0} + {4'b0000, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
    logic [7:0] r;
    case (mon)
      5'h02:                      r = is_leap(yr) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  function automatic hour_step_t hour_step(input logic [5:0] h, input logic m24);
    hour_step_t r;
    logic [7:0] t;
    r.day = 1'b0;
    if (m24) begin
      t = bcd_inc({2'b00, h});
      if (h >= 6'h23) begin
        r.hour = 6'h00;
        r.day  = 1'b1;
      end else begin
        r.hour = t[5:0];
      end
    end else begin
      t = bcd_inc({3'b000, h[4:0]});
      if (h[4:0] == 5'h12) begin
        r.hour = {h[5], 5'h01};
      end else if (h[4:0] == 5'h11) begin
        r.hour = {~h[5], 5'h12};
        r.day  = h[5];
      end else begin
        r.hour = {h[5], t[4:0]};
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
  parameter int TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode24,
  input  logic              adv,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [6:0]        sec,
  output logic [6:0]        min,
  output logic [5:0]        hour,
  output logic              min_c,
  output logic              hour_c,
  output logic              day_c
);
  hour_step_t nxt;
  logic [7:0] sec_inc, min_inc;

  always_comb begin
    sec_inc = bcd_inc({1'b0, sec});
    min_inc = bcd_inc({1'b0, min});
    nxt     = hour_step(hour, mode24);
    min_c   = adv && (sec >= 7'h59);
    hour_c  = min_c && (min >= 7'h59);
    day_c   = hour_c && nxt.day;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec  <= '0;
      min  <= '0;
      hour <= mode24 ? 6'h00 : 6'h12;
    end else begin
      if (wr_en && wr_addr == A_SEC) sec <= wr_data[6:0];
      else if (adv)                  sec <= min_c ? 7'h00 : sec_inc[6:0];

      if (wr_en && wr_addr == A_MIN) min <= wr_data[6:0];
      else if (min_c)                min <= hour_c ? 7'h00 : min_inc[6:0];

      if (wr_en && wr_addr == A_HOUR) hour <= wr_data[5:0];
      else if (hour_c)                hour <= nxt.hour;
    end
  end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [2:0]        wday,
  output logic [5:0]        mday,
  output logic [4:0]        mon,
  output logic              cent,
  output logic [7:0]        year,
  output logic              mon_c
);
  logic [7:0] last, mday_inc, mon_inc, yr_inc;
  logic       yr_c, yr_wrap;

  always_comb begin
    last     = last_day(mon, year);
    mday_inc = bcd_inc({2'b00, mday});
    mon_inc  = bcd_inc({3'b000, mon});
    yr_inc   = bcd_inc(year);
    mon_c    = adv && ({2'b00, mday} >= last);
    yr_c     = mon_c && (mon >= 5'h12);
    yr_wrap  = yr_c && (year >= 8'h99);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wday <= '0;
      mday <= 6'h01;
      mon  <= 5'h01;
      cent <= 1'b0;
      year <= 8'h00;
    end else begin
      if (wr_en && wr_addr == A_WDAY) wday <= wr_data[2:0];
      else if (adv)                   wday <= (wday >= 3'd6) ? 3'd0 : wday + 3'd1;

      if (wr_en && wr_addr == A_MDAY) mday <= wr_data[5:0];
      else if (adv)                   mday <= mon_c ? 6'h01 : mday_inc[5:0];

      if (wr_en && wr_addr == A_MON) begin
        mon  <= wr_data[4:0];
        cent <= wr_data[7];
      end else if (mon_c) begin
        mon <= yr_c ? 5'h01 : mon_inc[4:0];
        if (yr_wrap) cent <= ~cent;
      end

      if (wr_en && wr_addr == A_YEAR) year <= wr_data;
      else if (yr_c)                  year <= yr_wrap ? 8'h00 : yr_inc;
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode24,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              sec_stb,
  output logic              min_stb,
  output logic              hour_stb,
  output logic              day_stb,
  output logic              mon_stb
);
  logic       div_tick, div_clr, tick_pend, tick_req, adv;
  logic       min_c, hour_c, day_c, mon_c, cent;
  logic [6:0] sec, min;
  logic [5:0] hour, mday;
  logic [2:0] wday;
  logic [4:0] mon;
  logic [7:0] year;

  assign div_clr  = wr_en && (wr_addr == A_SEC);
  assign tick_req = div_tick || tick_pend;
  assign adv      = tick_req && !wr_en;

  rtc_subsec_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .clr (div_clr),
    .tick(div_tick)
  );

  rtc_time_chain u_time (
    .clk    (clk),
    .rst    (rst),
    .mode24 (mode24),
    .adv    (adv),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .sec    (sec),
    .min    (min),
    .hour   (hour),
    .min_c  (min_c),
    .hour_c (hour_c),
    .day_c  (day_c)
  );

  rtc_date_chain u_date (
    .clk    (clk),
    .rst    (rst),
    .adv    (day_c),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .wday   (wday),
    .mday   (mday),
    .mon    (mon),
    .cent   (cent),
    .year   (year),
    .mon_c  (mon_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_pend <= 1'b0;
      sec_stb   <= 1'b0;
      min_stb   <= 1'b0;
      hour_stb  <= 1'b0;
      day_stb   <= 1'b0;
      mon_stb   <= 1'b0;
      rd_data   <= '0;
    end else begin
      // a host write holds a due advance back one cycle; a seconds write drops it
      tick_pend <= tick_req && wr_en && !div_clr;
      sec_stb   <= adv;
      min_stb   <= min_c;
      hour_stb  <= hour_c;
      day_stb   <= day_c;
      mon_stb   <= mon_c;
      case (rd_addr)
        A_SEC:   rd_data <= {1'b0, sec};
        A_MIN:   rd_data <= {1'b0, min};
        A_HOUR:  rd_data <= {2'b00, hour};
        A_WDAY:  rd_data <= {5'b00000, wday};
        A_MDAY:  rd_data <= {2'b00, mday};
        A_MON:   rd_data <= {cent, 2'b00, mon};
        A_YEAR:  rd_data <= year;
        default: rd_data <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk #(
  parameter int TICK_DIV = 32768
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [2:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       sec_stb,
  input logic       min_stb,
  input logic       hour_stb,
  input logic       day_stb,
  input logic       mon_stb
);
  // R9
  min_nests_chk: assert property (@(posedge clk) disable iff (rst) min_stb |-> sec_stb);
  // R9
  hour_nests_chk: assert property (@(posedge clk) disable iff (rst) hour_stb |-> min_stb);
  // R9
  day_nests_chk: assert property (@(posedge clk) disable iff (rst) day_stb |-> hour_stb);
  // R9
  mon_nests_chk: assert property (@(posedge clk) disable iff (rst) mon_stb |-> day_stb);
  // R9
  sec_single_chk: assert property (@(posedge clk) disable iff (rst) sec_stb |=> !sec_stb);
  // R8
  sec_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0) |=> !sec_stb);
  // R2
  hole_zero_chk: assert property (@(posedge clk) disable iff (rst) (rd_addr == 3'd7) |=> (rd_data == 8'h00));
  // R2
  sec_top_zero_chk: assert property (@(posedge clk) disable iff (rst) (rd_addr == 3'd0) |=> !rd_data[7]);
  // R2
  wday_top_zero_chk: assert property (@(posedge clk) disable iff (rst) (rd_addr == 3'd3) |=> (rd_data[7:3] == 5'd0));
  // R2
  mon_gap_zero_chk: assert property (@(posedge clk) disable iff (rst) (rd_addr == 3'd5) |=> (rd_data[6:5] == 2'd0));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .sec_stb (sec_stb),
  .min_stb (min_stb),
  .hour_stb(hour_stb),
  .day_stb (day_stb),
  .mon_stb (mon_stb)
);

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
  localparam int TD = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode24 = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sec_stb, min_stb, hour_stb, day_stb, mon_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] rb [8];
  logic s_min, s_hour, s_day, s_mon;
  int lat;

  always #2 clk = ~clk;

  rtc_calendar_core #(.TICK_DIV(TD)) u_rtc_calendar_core (
    .clk(clk), .rst(rst), .mode24(mode24),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sec_stb(sec_stb), .min_stb(min_stb), .hour_stb(hour_stb),
    .day_stb(day_stb), .mon_stb(mon_stb)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] enc12(input int h);
    int hh;
    hh = h % 12;
    if (hh == 0) hh = 12;
    return (h >= 12 ? 8'h20 : 8'h00) | to_bcd(hh);
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    rd_addr = 3'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  // load all fields (seconds first), wait one advance, read everything back
  task automatic step(input logic [7:0] s, m, h, wd, md, mo, yr);
    wr(0, s); wr(1, m); wr(2, h); wr(3, wd); wr(4, md); wr(5, mo); wr(6, yr);
    lat = 6;
    while (!sec_stb && lat < 100) begin @(negedge clk); lat++; end
    s_min = min_stb; s_hour = hour_stb; s_day = day_stb; s_mon = mon_stb;
    for (int a = 0; a < 7; a++) rd(a, rb[a]);
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int ny, nm;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R12 reset values, 12-hour mode
    chk("R12 sec_stb", {7'b0, sec_stb}, 8'h00);
    chk("R12 day_stb", {7'b0, day_stb}, 8'h00);
    rd(0, d); chk("R12 sec", d, 8'h00);
    rd(1, d); chk("R12 min", d, 8'h00);
    rd(2, d); chk("R12 hour", d, 8'h12);
    rd(3, d); chk("R12 wday", d, 8'h00);
    rd(4, d); chk("R12 mday", d, 8'h01);
    rd(5, d); chk("R12 month", d, 8'h01);
    rd(6, d); chk("R12 year", d, 8'h00);

    // R2 masks and empty index
    mode24 = 1'b1;
    for (int a = 0; a < 8; a++) wr(a, 8'hFF);
    rd(0, d); chk("R2 sec mask", d, 8'h7F);
    rd(1, d); chk("R2 min mask", d, 8'h7F);
    rd(2, d); chk("R2 hour mask", d, 8'h3F);
    rd(3, d); chk("R2 wday mask", d, 8'h07);
    rd(4, d); chk("R2 mday mask", d, 8'h3F);
    rd(5, d); chk("R2 month mask", d, 8'h9F);
    rd(6, d); chk("R2 year", d, 8'hFF);
    rd(7, d); chk("R2 index7", d, 8'h00);

    // R1 seconds sweep
    for (int s = 0; s < 60; s++) begin
      step(to_bcd(s), 8'h30, 8'h10, 8'h02, 8'h10, 8'h05, 8'h21);
      chk("R1 sec", rb[0], to_bcd((s + 1) % 60));
      chk("R1 min", rb[1], s == 59 ? 8'h31 : 8'h30);
      chk("R9 min_stb", {7'b0, s_min}, s == 59 ? 8'h01 : 8'h00);
      chk("R9 hour_stb", {7'b0, s_hour}, 8'h00);
    end
    // R1 minutes sweep
    for (int m = 0; m < 60; m++) begin
      step(8'h59, to_bcd(m), 8'h10, 8'h02, 8'h10, 8'h05, 8'h21);
      chk("R1 min wrap", rb[1], to_bcd((m + 1) % 60));
      chk("R1 hour", rb[2], m == 59 ? 8'h11 : 8'h10);
      chk("R9 hour_stb", {7'b0, s_hour}, m == 59 ? 8'h01 : 8'h00);
    end

    // R3 / R4 hour sweeps in both modes
    for (int md = 0; md < 2; md++) begin
      mode24 = md[0];
      for (int h = 0; h < 24; h++) begin
        step(8'h59, 8'h59, md ? to_bcd(h) : enc12(h), 8'h02, 8'h10, 8'h05, 8'h21);
        if (md) chk("R4 hour24", rb[2], to_bcd((h + 1) % 24));
        else    chk("R3 hour12", rb[2], enc12((h + 1) % 24));
        chk(md ? "R4 day_stb" : "R3 day_stb", {7'b0, s_day}, h == 23 ? 8'h01 : 8'h00);
        chk("R3 mday", rb[4], h == 23 ? 8'h11 : 8'h10);
      end
    end

    // R5 day of week
    mode24 = 1'b1;
    for (int w = 0; w < 7; w++) begin
      step(8'h59, 8'h59, 8'h23, 8'(w), 8'h10, 8'h05, 8'h21);
      chk("R5 wday", rb[3], 8'((w + 1) % 7));
      chk("R9 mon_stb", {7'b0, s_mon}, 8'h00);
    end

    // R6 / R7 month ends over eight years
    for (int y = 0; y < 8; y++) begin
      for (int m = 1; m <= 12; m++) begin
        step(8'h59, 8'h59, 8'h23, 8'h01, to_bcd(mdays(m, y)), to_bcd(m), to_bcd(y));
        nm = (m == 12) ? 1 : m + 1;
        ny = (m == 12) ? y + 1 : y;
        chk("R6 mday wrap", rb[4], 8'h01);
        chk("R7 month", rb[5], to_bcd(nm));
        chk("R7 year", rb[6], to_bcd(ny));
        chk("R9 mon_stb", {7'b0, s_mon}, 8'h01);
      end
    end

    // R6 February 28 in every year
    for (int y = 0; y < 100; y++) begin
      step(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, to_bcd(y));
      chk("R6 feb mday", rb[4], (y % 4 == 0) ? 8'h29 : 8'h01);
      chk("R6 feb month", rb[5], (y % 4 == 0) ? 8'h02 : 8'h03);
    end

    // R7 century toggle both ways
    step(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    chk("R7 century set", rb[5], 8'h81);
    chk("R7 year wrap", rb[6], 8'h00);
    step(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h92, 8'h99);
    chk("R7 century clear", rb[5], 8'h01);

    // R8 divider cleared by a seconds write
    wr(0, 8'h10);
    lat = 0;
    while (!sec_stb && lat < 100) begin @(negedge clk); lat++; end
    chk("R8 first advance", 8'(lat), 8'(TD));
    @(negedge clk);
    chk("R9 sec_stb one cycle", {7'b0, sec_stb}, 8'h00);
    wr(0, 8'h20);
    lat = 0;
    for (int i = 0; i < 9; i++) begin @(negedge clk); if (sec_stb) lat++; end
    chk("R8 no early advance", 8'(lat), 8'h00);
    wr(0, 8'h40);
    lat = 0;
    while (!sec_stb && lat < 100) begin @(negedge clk); lat++; end
    chk("R8 restarted advance", 8'(lat), 8'(TD));
    rd(0, d); chk("R8 sec", d, 8'h41);

    // R13 write on the advance edge
    wr(0, 8'h05);
    repeat (TD - 1) @(negedge clk);
    chk("R13 before", {7'b0, sec_stb}, 8'h00);
    wr(1, 8'h44);
    chk("R13 held", {7'b0, sec_stb}, 8'h00);
    @(negedge clk);
    chk("R13 late advance", {7'b0, sec_stb}, 8'h01);
    rd(0, d); chk("R13 sec", d, 8'h06);
    rd(1, d); chk("R13 min", d, 8'h44);

    // R11 mode change keeps the stored hour; R10 read latency
    mode24 = 1'b0;
    wr(2, 8'h32);
    mode24 = 1'b1;
    rd(2, d); chk("R11 hour kept", d, 8'h32);
    rd_addr = 3'd1;
    @(negedge clk);
    rd_addr = 3'd2;
    chk("R10 latency", rd_data, 8'h44);

    finish_run();
  end
endmodule